// File: doc/BRIEF.md
# Single-Bit Operation Unit with Carry Accumulator

This block carries out one single-bit operation per cycle on a byte that has already been fetched from memory or from an I/O port. The bit it acts on is picked in one of two ways. It can be a 3-bit immediate field, or it can be the low bits of a general-purpose register value. The register form lets software step through a byte one bit at a time.

The unit keeps a one-bit carry register that works as a boolean accumulator. A load places a chosen bit in the carry. AND, OR and XOR steps then fold further bits into it, and a later branch, outside this block, tests the result. Other operations set, clear, toggle or store into the chosen bit and return the new byte with a write-back strobe. A test operation reports the chosen bit on a zero flag. Fetching and storing the byte and acting on the carry are left to the surrounding logic.

Every operation is accepted on a clock edge while `op_valid` is high. Its outputs become visible after that same edge. The carry written by one operation is therefore the carry used by the operation in the following cycle.

Top module: `bitop_unit`

## Requirements
- R1: While `rst_n` is low, `carry`, `zero`, `wb_en` and `result` are all 0.
- R2: With `use_reg`=0 the bit index is `imm_bit`. With `use_reg`=1 it is `reg_val[2:0]`, and the upper bits of `reg_val` have no effect. Bit 0 is the least significant bit of `operand`.
- R3: Opcode 0 (set), 1 (clear) and 2 (toggle) return `operand` with only the selected bit forced to 1, forced to 0 or inverted. They assert `wb_en` and leave `carry` and `zero` unchanged.
- R4: Opcode 3 writes `carry` into the selected bit and opcode 4 writes the inverse of `carry`. Both assert `wb_en` and leave `carry` unchanged.
- R5: Opcode 5 copies the selected bit into `carry` and opcode 6 copies its inverse. `wb_en` stays 0 and `result` equals `operand`.
- R6: Opcode 7 (test) sets `zero` to the inverse of the selected bit. It leaves `carry` unchanged, keeps `wb_en` at 0 and returns `operand` unchanged. No other opcode changes `zero`.
- R7: Opcodes 8/9 (AND), 10/11 (OR) and 12/13 (XOR) combine `carry` with the selected bit and leave the result in `carry`. The odd opcode of each pair uses the inverted bit. `wb_en` stays 0 and `result` equals `operand`.
- R8: Opcodes 14 and 15 leave `carry` and `zero` unchanged, return `operand` and keep `wb_en` at 0.
- R9: When `op_valid` is low, `wb_en` is 0 and `carry`, `zero` and `result` hold their values.
- R10: Outputs update on the clock edge that accepts the operation. An operation in the next cycle uses the carry produced by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| operand | input | 8 | Byte to act on |
| use_reg | input | 1 | 1: bit index from reg_val, 0: from imm_bit |
| imm_bit | input | 3 | Immediate bit index |
| reg_val | input | 16 | General-purpose register value |
| result | output | 8 | Byte after the operation |
| wb_en | output | 1 | Result must be written back |
| carry | output | 1 | Bit accumulator |
| zero | output | 1 | Inverse of the last tested bit |

## Verification
Two functions can meet in one cycle: the carry update from one operation and the use of that carry by the operation in the very next cycle. A store or a logical step can also pick its bit through the register path on that same cycle. The bench provokes this with unbroken chains of load, AND/OR/XOR (plain and inverted) and store, with no idle cycle between them and with index sources that alternate. Its scoreboard model carries its own carry forward from item to item, so a stale or early carry changes the stored bit or the final carry and is caught.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic [3:0]                opcode,
  input  logic [DATA_W-1:0]         operand,
  input  logic                      use_reg,
  input  logic [$clog2(DATA_W)-1:0] imm_bit,
  input  logic [REG_W-1:0]          reg_val,
  output logic [DATA_W-1:0]         result,
  output logic                      wb_en,
  output logic                      carry,
  output logic                      zero
);
  localparam int IDX_W = $clog2(DATA_W);

  localparam logic [3:0] OP_SET   = 4'd0;
  localparam logic [3:0] OP_CLR   = 4'd1;
  localparam logic [3:0] OP_NOT   = 4'd2;
  localparam logic [3:0] OP_ST    = 4'd3;
  localparam logic [3:0] OP_IST   = 4'd4;
  localparam logic [3:0] OP_LD    = 4'd5;
  localparam logic [3:0] OP_ILD   = 4'd6;
  localparam logic [3:0] OP_TST   = 4'd7;
  localparam logic [3:0] OP_AND   = 4'd8;
  localparam logic [3:0] OP_IAND  = 4'd9;
  localparam logic [3:0] OP_OR    = 4'd10;
  localparam logic [3:0] OP_IOR   = 4'd11;
  localparam logic [3:0] OP_XOR   = 4'd12;
  localparam logic [3:0] OP_IXOR  = 4'd13;

  logic [IDX_W-1:0]  idx;
  logic              sel_bit;
  logic [DATA_W-1:0] mask;
  logic              wr, new_bit, nxt_carry, nxt_zero;

  assign idx     = use_reg ? reg_val[IDX_W-1:0] : imm_bit;
  assign sel_bit = operand[idx];
  assign mask    = {{(DATA_W-1){1'b0}}, 1'b1} << idx;

  always_comb begin
    wr        = 1'b0;
    new_bit   = sel_bit;
    nxt_carry = carry;
    nxt_zero  = zero;
    case (opcode)
      OP_SET:  begin wr = 1'b1; new_bit = 1'b1;     end
      OP_CLR:  begin wr = 1'b1; new_bit = 1'b0;     end
      OP_NOT:  begin wr = 1'b1; new_bit = ~sel_bit; end
      OP_ST:   begin wr = 1'b1; new_bit = carry;    end
      OP_IST:  begin wr = 1'b1; new_bit = ~carry;   end
      OP_LD:   nxt_carry = sel_bit;
      OP_ILD:  nxt_carry = ~sel_bit;
      OP_TST:  nxt_zero  = ~sel_bit;
      OP_AND:  nxt_carry = carry & sel_bit;
      OP_IAND: nxt_carry = carry & ~sel_bit;
      OP_OR:   nxt_carry = carry | sel_bit;
      OP_IOR:  nxt_carry = carry | ~sel_bit;
      OP_XOR:  nxt_carry = carry ^ sel_bit;
      OP_IXOR: nxt_carry = carry ^ ~sel_bit;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      wb_en  <= 1'b0;
      carry  <= 1'b0;
      zero   <= 1'b0;
    end else if (op_valid) begin
      result <= wr ? ((operand & ~mask) | (new_bit ? mask : '0)) : operand;
      wb_en  <= wr;
      carry  <= nxt_carry;
      zero   <= nxt_zero;
    end else begin
      wb_en  <= 1'b0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> (!carry && !zero && !wb_en && result == '0));

  assert_wb_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $countones(result ^ $past(operand)) <= 1);

  assert_wb_needs_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(op_valid));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && $past(rst_n)) |=> ($stable(carry) && $stable(zero) && $stable(result)));

  assert_test_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == OP_TST) |=> (!wb_en && $stable(carry) && result == $past(operand)));

  assert_zero_only_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode != OP_TST && $past(rst_n)) |=> $stable(zero));

  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode >= 4'd14 && $past(rst_n)) |=> (!wb_en && $stable(carry) && $stable(zero)));
endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [7:0]  operand = '0;
  logic        use_reg = 1'b0;
  logic [2:0]  imm_bit = '0;
  logic [15:0] reg_val = '0;
  logic [7:0]  result;
  logic        wb_en, carry, zero;

  always #4 clk = ~clk;

  bitop_unit dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .operand(operand), .use_reg(use_reg), .imm_bit(imm_bit), .reg_val(reg_val),
    .result(result), .wb_en(wb_en), .carry(carry), .zero(zero));

  typedef struct packed { logic [7:0] res; logic wb; logic c; logic z; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    errors = 0, checks = 0;
  logic  m_c = 0, m_z = 0;
  logic [7:0] m_res = 0;
  bit    done = 0;

  task automatic check_now(input exp_t e, input string tag);
    checks++;
    if ({result, wb_en, carry, zero} !== e) begin
      errors++;
      $display("FAIL %s: got res=%h wb=%b c=%b z=%b expected res=%h wb=%b c=%b z=%b",
               tag, result, wb_en, carry, zero, e.res, e.wb, e.c, e.z);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check_now(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic drive(input logic [3:0] op, input logic [7:0] b, input logic ur,
                       input logic [2:0] ib, input logic [15:0] rv, input string tag);
    logic [2:0] i;
    logic bit_v;
    logic wb;
    @(negedge clk);
    op_valid = 1; opcode = op; operand = b; use_reg = ur; imm_bit = ib; reg_val = rv;
    i = ur ? rv[2:0] : ib;
    bit_v = b[i];
    wb = 0;
    m_res = b;
    case (op)
      4'd0: begin wb = 1; m_res[i] = 1'b1; end
      4'd1: begin wb = 1; m_res[i] = 1'b0; end
      4'd2: begin wb = 1; m_res[i] = ~bit_v; end
      4'd3: begin wb = 1; m_res[i] = m_c; end
      4'd4: begin wb = 1; m_res[i] = ~m_c; end
      4'd5: m_c = bit_v;
      4'd6: m_c = ~bit_v;
      4'd7: m_z = ~bit_v;
      4'd8: m_c = m_c & bit_v;
      4'd9: m_c = m_c & ~bit_v;
      4'd10: m_c = m_c | bit_v;
      4'd11: m_c = m_c | ~bit_v;
      4'd12: m_c = m_c ^ bit_v;
      4'd13: m_c = m_c ^ ~bit_v;
      default: ;
    endcase
    exp_q.push_back('{res: m_res, wb: wb, c: m_c, z: m_z});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    op_valid = 0; opcode = 4'd0; operand = 8'hFF; reg_val = 16'h0007;
    exp_q.push_back('{res: m_res, wb: 1'b0, c: m_c, z: m_z});
    tag_q.push_back(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check_now('{res: 8'h00, wb: 1'b0, c: 1'b0, z: 1'b0}, "R1 reset");
    @(negedge clk); rst_n = 1;

    drive(4'd0, 8'h00, 0, 3'd0, 16'h0, "R3 set bit0");
    drive(4'd0, 8'h00, 0, 3'd7, 16'h0, "R3 set bit7");
    drive(4'd1, 8'hFF, 0, 3'd4, 16'h0, "R3 clear bit4");
    drive(4'd2, 8'h5A, 0, 3'd1, 16'h0, "R3 toggle bit1");
    drive(4'd2, 8'h5A, 1, 3'd0, 16'hFFF3, "R2 R3 toggle via reg idx3");
    drive(4'd0, 8'h00, 1, 3'd6, 16'hAB05, "R2 reg upper bits ignored");

    drive(4'd5, 8'h20, 1, 3'd0, 16'h0005, "R5 R10 load bit5 via reg");
    drive(4'd3, 8'h00, 0, 3'd2, 16'h0, "R4 R10 store carry back-to-back");
    drive(4'd4, 8'hFF, 0, 3'd6, 16'h0, "R4 store inverse");
    drive(4'd6, 8'h20, 0, 3'd5, 16'h0, "R5 inverse load");
    drive(4'd10, 8'h01, 1, 3'd0, 16'h0008, "R7 R10 OR chained");
    drive(4'd8, 8'hFE, 0, 3'd0, 16'h0, "R7 AND clears");
    drive(4'd11, 8'hFF, 1, 3'd0, 16'h0002, "R7 OR inverted no change");
    drive(4'd13, 8'h00, 0, 3'd3, 16'h0, "R7 XOR inverted sets");
    drive(4'd12, 8'h80, 0, 3'd7, 16'h0, "R7 XOR clears");
    drive(4'd9, 8'h00, 0, 3'd1, 16'h0, "R7 AND inverted");
    drive(4'd5, 8'h04, 0, 3'd2, 16'h0, "R5 load one");
    drive(4'd9, 8'h00, 1, 3'd0, 16'h0004, "R7 R10 AND inverted keeps one");
    drive(4'd3, 8'h00, 1, 3'd0, 16'h0006, "R4 R10 store via reg");

    for (int k = 0; k < 8; k++) drive(4'd7, 8'hA5, 1, 3'd0, 16'h0100 + 16'(k), "R6 R2 scan test");
    drive(4'd7, 8'h00, 0, 3'd3, 16'h0, "R6 test zero bit");
    drive(4'd5, 8'h01, 0, 3'd0, 16'h0, "R6 zero held by load");

    drive(4'd14, 8'h3C, 0, 3'd2, 16'h0, "R8 reserved 14");
    drive(4'd15, 8'hC3, 1, 3'd0, 16'h0001, "R8 reserved 15");
    drive(4'd0, 8'h10, 0, 3'd0, 16'h0, "R3 set before idle");
    idle("R9 idle hold 1");
    idle("R9 idle hold 2");
    drive(4'd3, 8'hF0, 0, 3'd0, 16'h0, "R10 store after idle");
    idle("R9 idle after store");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule